// File: doc/BRIEF.md
# Shared Issue-Queue Entry Allocator for Multithreaded Cores

This block sits beside a shared instruction issue queue that several hardware threads fill at the same time. The storage itself lives elsewhere. The allocator does the bookkeeping. It keeps one occupancy counter per thread and one count of free entries. It also holds a per-thread entry limit, and it decides each cycle which thread insert requests are admitted.

The per-thread limit follows a sharing policy that can be changed at run time:

- **Dynamic:** any thread may take the whole queue.
- **Partitioned:** the queue is split evenly across the threads.
- **Threshold:** each thread may take a fixed percentage of the queue. If exactly one thread is active, that thread may take the whole queue.

Entries come back through two per-thread pulses, one for squashes and one for issue. A request that cannot be admitted leaves the counters alone and raises a one-cycle error flag for that thread.

Top module: `iq_slot_alloc`

## Requirements
- R1: In the cycle after synchronous reset (`rst` high) is released, every occupancy count is 0, `free_cnt` equals QDEPTH, `ins_err` is 0, `thr_full` is 0 and every limit equals QDEPTH.
- R2: With `pol_sel` = 0 (dynamic) or 3 (treated as dynamic), every thread's limit is QDEPTH.
- R3: With `pol_sel` = 1 (partitioned), every thread's limit is QDEPTH / NUM_THR, rounded down.
- R4: With `pol_sel` = 2 (threshold), a thread's limit is floor(p × QDEPTH / 100), where p is `share_pct` clamped to at most 100.
- R5: Under the threshold policy, when `act_mask` has exactly one bit set, the thread of that bit has limit QDEPTH. The other threads keep the threshold limit.
- R6: Limits are registered from `pol_sel`, `act_mask` and `share_pct` at each clock edge and take effect in the following cycle. A change of policy never alters any occupancy count.
- R7: `thr_full[i]` is 1 exactly when thread i's count is at or above its limit, or when `free_cnt` is 0.
- R8: Requests are granted lowest thread index first. Thread i's request is granted only if it is not full and fewer than `free_cnt` lower-index threads were granted in the same cycle.
- R9: A request that is not granted leaves the count unchanged. It sets `ins_err[i]` for exactly the next cycle. `ins_err[i]` is never set without a request in the previous cycle.
- R10: Each cycle a thread's count rises by 1 if its request is granted. It falls by `sq_rel[i]` + `iss_rel[i]`, capped at the count held at the start of the cycle, so releases at zero are ignored.
- R11: `free_cnt` always equals QDEPTH minus the sum of all counts, so it never exceeds QDEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_req | input | NUM_THR | Per-thread insert request |
| sq_rel | input | NUM_THR | Per-thread release of one entry by squash |
| iss_rel | input | NUM_THR | Per-thread release of one entry by issue |
| act_mask | input | NUM_THR | Active-thread mask |
| pol_sel | input | 2 | Sharing policy: 0 dynamic, 1 partitioned, 2 threshold, 3 dynamic |
| share_pct | input | PCT_W | Threshold percentage (values above 100 clamp to 100) |
| thr_full | output | NUM_THR | Per-thread full flag |
| ins_err | output | NUM_THR | Per-thread rejected-insert flag, one cycle after the request |
| free_cnt | output | CW | Free queue entries |
| occ_cnt | output | NUM_THR*CW | Per-thread occupancy, thread i at bits [i*CW +: CW] |

## Verification
The assertions assume that the release pulses describe entries the thread really holds. The allocator tolerates releases beyond the count by capping them, so the occupancy and free-count invariants hold even when this assumption is broken.

The assertions also assume that `rst` is held high from time zero until the inputs are defined. The bench holds reset over several edges before it drives anything. Its random traffic mixes requests, squash pulses and issue pulses, and it changes policy, mask and percentage (including values above 100) at intervals. Every cycle it compares the outputs against a model built from the requirements.

// File: rtl/iqa_pkg.sv
package iqa_pkg;

    typedef enum logic [1:0] {
        POL_DYN   = 2'd0,
        POL_PART  = 2'd1,
        POL_THR   = 2'd2,
        POL_DYN_B = 2'd3
    } share_pol_e;

    localparam int PCT_MAX = 100;

    // Percentage share of a queue, percentage clamped to PCT_MAX, truncated.
    function automatic int share_of(input int pct, input int depth);
        int p;
        p = (pct > PCT_MAX) ? PCT_MAX : pct;
        return (p * depth) / PCT_MAX;
    endfunction

endpackage

// File: rtl/iqa_limit_calc.sv
module iqa_limit_calc
    import iqa_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int QDEPTH  = 64,
    parameter int PCT_W   = 7,
    parameter int CW      = $clog2(QDEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_THR-1:0]    act_mask,
    input  logic [1:0]            pol_sel,
    input  logic [PCT_W-1:0]      share_pct,
    output logic [NUM_THR*CW-1:0] lim_flat
);
    localparam int PART_LIM = QDEPTH / NUM_THR;

    share_pol_e pol;
    logic       one_active;
    logic [CW-1:0] thr_share;

    assign pol        = share_pol_e'(pol_sel);
    assign one_active = ($countones(act_mask) == 1);
    assign thr_share  = CW'(share_of(int'(share_pct), QDEPTH));

    for (genvar t = 0; t < NUM_THR; t++) begin : g_lim
        logic [CW-1:0] lim_d, lim_q;

        always_comb begin
            case (pol)
                POL_PART: lim_d = CW'(PART_LIM);
                POL_THR:  lim_d = (one_active && act_mask[t]) ? CW'(QDEPTH) : thr_share;
                default:  lim_d = CW'(QDEPTH);
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) lim_q <= CW'(QDEPTH);
            else     lim_q <= lim_d;
        end

        assign lim_flat[t*CW +: CW] = lim_q;

        AST_LIM_BOUND: assert property (@(posedge clk) disable iff (rst)
            lim_q <= CW'(QDEPTH)); // R4
        AST_PART_LIM: assert property (@(posedge clk) disable iff (rst)
            (pol_sel == 2'd1) |=> (lim_q == CW'(PART_LIM))); // R3
    end

endmodule

// File: rtl/iqa_admit.sv
module iqa_admit #(
    parameter int NUM_THR = 4,
    parameter int CW      = 7
) (
    input  logic [NUM_THR-1:0]    ins_req,
    input  logic [NUM_THR*CW-1:0] cnt_flat,
    input  logic [NUM_THR*CW-1:0] lim_flat,
    input  logic [CW-1:0]         free_cnt,
    output logic [NUM_THR-1:0]    full,
    output logic [NUM_THR-1:0]    grant,
    output logic [NUM_THR-1:0]    reject
);
    logic [CW-1:0] used;

    // Lower thread index wins when free entries run short.
    always_comb begin
        used = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            full[i]   = (cnt_flat[i*CW +: CW] >= lim_flat[i*CW +: CW]) || (free_cnt == '0);
            grant[i]  = ins_req[i] && !full[i] && (used < free_cnt);
            reject[i] = ins_req[i] && !grant[i];
            used      = used + CW'(grant[i]);
        end
    end

endmodule

// File: rtl/iqa_thread_ctr.sv
module iqa_thread_ctr #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant,
    input  logic          reject,
    input  logic          full,
    input  logic          sq_rel,
    input  logic          iss_rel,
    output logic [CW-1:0] cnt_q,
    output logic [1:0]    rel_amt,
    output logic          err_q
);
    logic [1:0] rel_req;

    assign rel_req = {1'b0, sq_rel} + {1'b0, iss_rel};
    // Releases cannot take the count below zero.
    assign rel_amt = (cnt_q < CW'(rel_req)) ? cnt_q[1:0] : rel_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CW'(grant) - CW'(rel_amt);
            err_q <= reject;
        end
    end

    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        full |=> (cnt_q <= $past(cnt_q))); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ##1 ((CW+1)'(cnt_q) <= (CW+1)'($past(cnt_q)) + (CW+1)'(1))); // R10

endmodule

// File: rtl/iq_slot_alloc.sv
module iq_slot_alloc
    import iqa_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int QDEPTH  = 64,
    parameter int PCT_W   = 7,
    localparam int CW     = $clog2(QDEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_THR-1:0]    ins_req,
    input  logic [NUM_THR-1:0]    sq_rel,
    input  logic [NUM_THR-1:0]    iss_rel,
    input  logic [NUM_THR-1:0]    act_mask,
    input  logic [1:0]            pol_sel,
    input  logic [PCT_W-1:0]      share_pct,
    output logic [NUM_THR-1:0]    thr_full,
    output logic [NUM_THR-1:0]    ins_err,
    output logic [CW-1:0]         free_cnt,
    output logic [NUM_THR*CW-1:0] occ_cnt
);
    localparam int SW = CW + $clog2(NUM_THR) + 2;

    logic [NUM_THR*CW-1:0] lim_flat;
    logic [NUM_THR-1:0]    grant, reject;
    logic [2*NUM_THR-1:0]  rel_flat;
    logic [CW-1:0]         free_q;
    logic [SW-1:0]         gain, loss, occ_sum;

    iqa_limit_calc #(.NUM_THR(NUM_THR), .QDEPTH(QDEPTH), .PCT_W(PCT_W), .CW(CW)) u_lim (
        .clk(clk), .rst(rst), .act_mask(act_mask), .pol_sel(pol_sel),
        .share_pct(share_pct), .lim_flat(lim_flat)
    );

    iqa_admit #(.NUM_THR(NUM_THR), .CW(CW)) u_adm (
        .ins_req(ins_req), .cnt_flat(occ_cnt), .lim_flat(lim_flat),
        .free_cnt(free_q), .full(thr_full), .grant(grant), .reject(reject)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        iqa_thread_ctr #(.CW(CW)) u_ctr (
            .clk(clk), .rst(rst), .grant(grant[t]), .reject(reject[t]),
            .full(thr_full[t]), .sq_rel(sq_rel[t]), .iss_rel(iss_rel[t]),
            .cnt_q(occ_cnt[t*CW +: CW]), .rel_amt(rel_flat[2*t +: 2]),
            .err_q(ins_err[t])
        );
    end

    always_comb begin
        gain    = '0;
        loss    = '0;
        occ_sum = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            gain    = gain + SW'(rel_flat[2*i +: 2]);
            loss    = loss + SW'(grant[i]);
            occ_sum = occ_sum + SW'(occ_cnt[i*CW +: CW]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= CW'(QDEPTH);
        else     free_q <= CW'(SW'(free_q) + gain - loss);
    end

    assign free_cnt = free_q;

    AST_FREE_SUM: assert property (@(posedge clk) disable iff (rst)
        (SW'(free_q) + occ_sum) == SW'(QDEPTH)); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        free_q <= CW'(QDEPTH)); // R11
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ##1 ((ins_err & ~$past(ins_req)) == '0)); // R9
    AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (free_q == CW'(QDEPTH) && occ_sum == '0 && ins_err == '0)); // R1

endmodule

// File: tb/sim_iq_slot_alloc.sv
module sim_iq_slot_alloc;
    localparam int NT = 4;
    localparam int QD = 64;
    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT-1:0] ins_req = '0, sq_rel = '0, iss_rel = '0;
    logic [NT-1:0] act_mask = '1;
    logic [1:0]    pol_sel = 2'd0;
    logic [6:0]    share_pct = 7'd50;
    logic [NT-1:0] thr_full, ins_err;
    logic [CW-1:0] free_cnt;
    logic [NT*CW-1:0] occ_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int m_cnt[NT];
    int m_lim[NT];
    int m_free;
    bit m_err[NT];

    iq_slot_alloc #(.NUM_THR(NT), .QDEPTH(QD), .PCT_W(7)) u0 (
        .clk(clk), .rst(rst), .ins_req(ins_req), .sq_rel(sq_rel), .iss_rel(iss_rel),
        .act_mask(act_mask), .pol_sel(pol_sel), .share_pct(share_pct),
        .thr_full(thr_full), .ins_err(ins_err), .free_cnt(free_cnt), .occ_cnt(occ_cnt)
    );

    always #4 clk = ~clk;

    function automatic int occ(int i);
        return int'(occ_cnt[i*CW +: CW]);
    endfunction

    function automatic int lim_of(int t);
        int p;
        int ones;
        ones = $countones(act_mask);
        if (pol_sel == 2'd1) return QD / NT;
        if (pol_sel == 2'd2) begin
            if (ones == 1 && act_mask[t]) return QD;
            p = (share_pct > 100) ? 100 : int'(share_pct);
            return (p * QD) / 100;
        end
        return QD;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One cycle: drive at the falling edge, check full flags, model the rising edge, check state.
    task automatic step(logic [NT-1:0] rq, logic [NT-1:0] sq, logic [NT-1:0] is);
        bit mf[NT];
        int used, nc[NT], nfree, rel, dec;
        bit acc;
        @(negedge clk);
        ins_req = rq; sq_rel = sq; iss_rel = is;
        #1;
        used = 0;
        nfree = m_free;
        for (int i = 0; i < NT; i++) begin
            mf[i] = (m_cnt[i] >= m_lim[i]) || (m_free == 0);
            chk(thr_full[i] == mf[i], "R7 full flag", int'(thr_full[i]), int'(mf[i]));
            acc = rq[i] && !mf[i] && (used < m_free);
            if (acc) used++;
            m_err[i] = rq[i] && !acc;
            rel = int'(sq[i]) + int'(is[i]);
            dec = (rel > m_cnt[i]) ? m_cnt[i] : rel;
            nc[i] = m_cnt[i] + int'(acc) - dec;
            nfree = nfree + dec;
        end
        nfree = nfree - used;
        @(posedge clk);
        for (int i = 0; i < NT; i++) begin
            m_cnt[i] = nc[i];
            m_lim[i] = lim_of(i);
        end
        m_free = nfree;
        #1;
        for (int i = 0; i < NT; i++) begin
            chk(occ(i) == m_cnt[i], "R10 occupancy", occ(i), m_cnt[i]);
            chk(ins_err[i] == m_err[i], "R9 error flag", int'(ins_err[i]), int'(m_err[i]));
        end
        chk(int'(free_cnt) == m_free, "R11 free count", int'(free_cnt), m_free);
    endtask

    task automatic drain();
        int tot;
        tot = 1;
        while (tot > 0) begin
            step('0, '1, '1);
            tot = 0;
            for (int i = 0; i < NT; i++) tot += m_cnt[i];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NT; i++) begin
            m_cnt[i] = 0; m_lim[i] = QD; m_err[i] = 0;
        end
        m_free = QD;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(int'(free_cnt) == QD, "R1 free after reset", int'(free_cnt), QD);
        chk(occ_cnt == '0, "R1 counts after reset", int'(occ_cnt != '0), 0);
        chk(ins_err == '0, "R1 err after reset", int'(ins_err), 0);
        chk(thr_full == '0, "R1 full after reset", int'(thr_full), 0);

        // R2: dynamic, one thread takes the whole queue
        pol_sel = 2'd0;
        for (int k = 0; k < QD; k++) step(4'b0001, '0, '0);
        #1;
        chk(occ(0) == QD, "R2 thread0 holds whole queue", occ(0), QD);
        chk(thr_full == 4'b1111, "R7 all full at zero free", int'(thr_full), 15);
        step(4'b0010, '0, '0);
        chk(ins_err == 4'b0010, "R9 reject raises err", int'(ins_err), 2);
        chk(occ(1) == 0, "R9 rejected count unchanged", occ(1), 0);
        step('0, '0, '0);
        chk(ins_err == '0, "R9 err lasts one cycle", int'(ins_err), 0);
        drain();

        // R10: release at zero ignored
        step('0, 4'b1000, 4'b1000);
        chk(occ(3) == 0, "R10 release at zero", occ(3), 0);
        chk(int'(free_cnt) == QD, "R10 free unchanged by empty release", int'(free_cnt), QD);

        // R3: partitioned
        pol_sel = 2'd1;
        for (int k = 0; k < 20; k++) step(4'b0010, '0, '0);
        chk(occ(1) == QD / NT, "R3 partition limit", occ(1), QD / NT);
        chk(ins_err[1] == 1'b1, "R3 excess insert rejected", int'(ins_err[1]), 1);
        drain();

        // R4: threshold 37% -> floor(37*64/100)=23
        pol_sel = 2'd2; share_pct = 7'd37; act_mask = 4'b1111;
        for (int k = 0; k < 30; k++) step(4'b0100, '0, '0);
        chk(occ(2) == 23, "R4 threshold limit", occ(2), 23);

        // R6: policy change keeps counts; limit shrinks next cycle
        pol_sel = 2'd1;
        step('0, '0, '0);
        chk(occ(2) == 23, "R6 count kept across policy change", occ(2), 23);
        chk(thr_full[2] == 1'b1, "R6 new limit applied", int'(thr_full[2]), 1);
        drain();

        // R4: percentage above 100 clamps to 100
        pol_sel = 2'd2; share_pct = 7'd120;
        for (int k = 0; k < QD; k++) step(4'b1000, '0, '0);
        chk(occ(3) == QD, "R4 clamped percentage", occ(3), QD);
        drain();

        // R5: single active thread under threshold
        share_pct = 7'd25; act_mask = 4'b0100;
        for (int k = 0; k < 40; k++) step(4'b0101, '0, '0);
        chk(occ(2) == 40, "R5 lone active thread beyond share", occ(2), 40);
        chk(occ(0) == 16, "R5 inactive thread keeps share", occ(0), 16);
        drain();

        // R8: contention for the last free entry
        pol_sel = 2'd0; act_mask = 4'b1111;
        for (int k = 0; k < QD - 1; k++) step(4'b0001, '0, '0);
        step(4'b0110, '0, '0);
        chk(occ(1) == 1 && occ(2) == 0, "R8 lower index wins", occ(1) * 10 + occ(2), 10);
        chk(ins_err == 4'b0100, "R8 loser flagged", int'(ins_err), 4);
        drain();

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            logic [NT-1:0] rq, sq, is;
            if (c % 250 == 0) begin
                pol_sel = 2'($urandom_range(0, 3));
                act_mask = 4'($urandom_range(1, 15));
                share_pct = 7'($urandom_range(0, 127));
            end
            for (int i = 0; i < NT; i++) begin
                rq[i] = ($urandom_range(0, 99) < 60);
                sq[i] = ($urandom_range(0, 99) < 10);
                is[i] = ($urandom_range(0, 99) < 18);
            end
            step(rq, sq, is);
        end
        finish_run();
    end

endmodule